// File: doc/BRIEF.md
# I2C DAC Holding-Register Write Target

This block is an I2C target that accepts write frames meant for a single-channel DAC holding register. It oversamples the bus lines with the system clock. It recognises start and stop conditions on the synchronised lines. It then shifts in four bytes, most significant bit first:

- the device address with the direction bit,
- a command byte,
- an upper data byte,
- a lower data byte.

It acknowledges each byte it accepts by enabling an open-drain pull-down on SDA.

When the acknowledge that follows the lower data byte ends, the block publishes the frame on its parallel output and raises a strobe for one cycle. The published frame is the command byte as a register index and the two data bytes joined into one 16-bit word. A complete update therefore takes 36 SCL cycles. Frames that are cut short produce no update. A wrong address is not acknowledged, and neither is a read request after its address byte. In both cases the block keeps quiet until the next start.

The controller has seven states:

- **IDLE**: waiting for a start.
- **ADDR**: receiving the address byte.
- **CMD**: receiving the command byte.
- **DHI**: receiving the upper data byte.
- **DLO**: receiving the lower data byte.
- **ACK**: driving an acknowledge.
- **SKIP**: off the bus until the next start or stop.

Its transitions are:

- **start** (any state → ADDR)
- **stop** (any state → IDLE)
- **addr_match** (ADDR → ACK)
- **addr_miss** (ADDR → SKIP)
- **byte_done** (CMD/DHI/DLO → ACK)
- **ack_next** (ACK → CMD/DHI/DLO)
- **ack_read** (ACK after a read address → SKIP)
- **commit** (ACK after the lower data byte → SKIP).

Top module: `i2cdac_wr_target`

## Requirements
- R1: While reset is low and right after it, the SDA pull-down is off, the update strobe is 0, and the index and data outputs are 0.
- R2: On the two-flop synchronised lines, an SDA fall while SCL is high is a start and always restarts address reception. An SDA rise while SCL is high is a stop and returns the block to idle.
- R3: When bits 7..1 of the address byte equal `dev_addr` and bit 0 (direction) is 0, the block holds SDA low for the whole high phase of the ninth SCL pulse.
- R4: When the address bits differ from `dev_addr`, that address byte and every later byte up to the next start get no acknowledge, and no update strobe occurs.
- R5: In a matching write frame, the command byte and both data bytes are each acknowledged on their ninth SCL pulse. Data bits are taken MSB first on SCL rising edges.
- R6: On the SCL falling edge that ends the acknowledge of the lower data byte, `upd_stb_o` is 1 for exactly one clock cycle. At the same time `upd_idx_o` takes the command byte and `upd_data_o` takes {upper byte, lower byte}. These outputs change at no other time.
- R7: A frame ended by a stop or a repeated start before the lower data byte's acknowledge completes gives no strobe and leaves `upd_idx_o`/`upd_data_o` unchanged. A repeated start begins a fresh frame.
- R8: A matching address with direction bit 1 is acknowledged. The next byte is then not acknowledged, and no strobe occurs.
- R9: The SDA pull-down changes only while synchronised SCL is low. It is enabled after the eighth SCL falling edge of a byte and released after the ninth, so it is off once each acknowledge ends and after a stop.
- R10: After a committed frame, further bytes before the next start are not acknowledged and cause no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| dev_addr | input | 7 | Fixed 7-bit device address |
| sda_pull_o | output | 1 | 1 enables the open-drain pull-down on SDA |
| upd_idx_o | output | 8 | Register index (command byte) of the last update |
| upd_data_o | output | 16 | Data word of the last update |
| upd_stb_o | output | 1 | One-cycle update strobe |

## Verification
The assertions assume a well-behaved bus master that follows the I2C line rules:

- SDA changes only while SCL is low, except for start and stop conditions.
- A start or stop is never issued while the target is pulling SDA low.
- Each SCL phase lasts several system clocks, so every edge survives the synchroniser as a separate event.

The bench's master model drives SCL with ten system clocks per quarter bit. It moves SDA only in the middle of the low phase, and it releases SDA during every acknowledge slot. The stop and repeated-start aborts it exercises are therefore always placed at byte boundaries, where the pull-down is already off.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DHI,
        ST_DLO,
        ST_ACK,
        ST_SKIP
    } st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cdac_sync.sv
module i2cdac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cdac_fsm.sv
module i2cdac_fsm
    import i2cdac_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [ADDR_W-1:0]     dev_addr,
    output logic                  sda_pull,
    output logic                  commit,
    output logic [BYTE_W-1:0]     cmd_byte,
    output logic [2*BYTE_W-1:0]   data_word
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    st_e               st, nxt;
    st_e               ack_of;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] dhi_q;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q;
    logic              receiving;
    logic              byte_done;

    assign receiving = (st == ST_ADDR) || (st == ST_CMD) ||
                       (st == ST_DHI)  || (st == ST_DLO);
    assign byte_done = receiving && scl_fall && (bitcnt == CNT_W'(BYTE_W));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: if (byte_done)
                             nxt = (shreg[BYTE_W-1:1] == dev_addr) ? ST_ACK : ST_SKIP;
                ST_CMD,
                ST_DHI,
                ST_DLO:  if (byte_done) nxt = ST_ACK;
                ST_ACK:  if (scl_fall) begin
                             unique case (ack_of)
                                 ST_ADDR: nxt = rw_q ? ST_SKIP : ST_CMD;
                                 ST_CMD:  nxt = ST_DHI;
                                 ST_DHI:  nxt = ST_DLO;
                                 default: nxt = ST_SKIP;
                             endcase
                         end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            dhi_q    <= '0;
            cmd_byte <= '0;
            bitcnt   <= '0;
            rw_q     <= 1'b0;
            ack_of   <= ST_ADDR;
            sda_pull <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            if (receiving && scl_rise && (bitcnt < CNT_W'(BYTE_W))) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (byte_done) begin
                bitcnt   <= '0;
                ack_of   <= st;
                sda_pull <= (nxt == ST_ACK);
                if (st == ST_ADDR) rw_q     <= shreg[0];
                if (st == ST_CMD)  cmd_byte <= shreg;
                if (st == ST_DHI)  dhi_q    <= shreg;
            end
            if ((st == ST_ACK) && scl_fall) sda_pull <= 1'b0;
        end
    end

    assign commit    = (st == ST_ACK) && scl_fall && (ack_of == ST_DLO) &&
                       !start_det && !stop_det;
    assign data_word = {dhi_q, shreg};

endmodule

// File: rtl/i2cdac_out_reg.sv
module i2cdac_out_reg #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] data_q,
    output logic              stb_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            data_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= commit;
            if (commit) begin
                idx_q  <= idx_in;
                data_q <= data_in;
            end
        end
    end

endmodule

// File: rtl/i2cdac_wr_target.sv
module i2cdac_wr_target
    import i2cdac_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int SYNC_STG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [ADDR_W-1:0]     dev_addr,
    output logic                  sda_pull_o,
    output logic [BYTE_W-1:0]     upd_idx_o,
    output logic [2*BYTE_W-1:0]   upd_data_o,
    output logic                  upd_stb_o
);

    localparam int DATA_W = 2 * BYTE_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              commit;
    logic [BYTE_W-1:0] cmd_byte;
    logic [DATA_W-1:0] data_word;

    i2cdac_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cdac_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .sda_pull  (sda_pull_o),
        .commit    (commit),
        .cmd_byte  (cmd_byte),
        .data_word (data_word)
    );

    i2cdac_out_reg #(.IDX_W(BYTE_W), .DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .idx_in  (cmd_byte),
        .data_in (data_word),
        .idx_q   (upd_idx_o),
        .data_q  (upd_data_o),
        .stb_q   (upd_stb_o)
    );

endmodule

// File: rtl/i2cdac_chk.sv
module i2cdac_chk #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              stop_det,
    input logic              sda_pull_o,
    input logic              upd_stb_o,
    input logic [IDX_W-1:0]  upd_idx_o,
    input logic [DATA_W-1:0] upd_data_o
);

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);  // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);  // R2

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> !upd_stb_o);  // R6

    AST_STB_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |-> $past(scl_fall));  // R6

    AST_OUT_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(upd_data_o) && $stable(upd_idx_o)) |-> upd_stb_o);  // R7

    AST_STB_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |-> !sda_pull_o);  // R9

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!upd_stb_o || $isunknown(upd_stb_o));  // R1
        end
    end

endmodule

bind i2cdac_wr_target i2cdac_chk #(.IDX_W(8), .DATA_W(16)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .scl_fall   (scl_fall),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .upd_stb_o  (upd_stb_o),
    .upd_idx_o  (upd_idx_o),
    .upd_data_o (upd_data_o)
);

// File: tb/sim_i2cdac_wr_target.sv
module sim_i2cdac_wr_target;

    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_pull_o;
    logic [7:0]  upd_idx_o;
    logic [15:0] upd_data_o;
    logic        upd_stb_o;
    logic        sda_bus;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = ~(m_low | sda_pull_o);

    i2cdac_wr_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .dev_addr   (DEV),
        .sda_pull_o (sda_pull_o),
        .upd_idx_o  (upd_idx_o),
        .upd_data_o (upd_data_o),
        .upd_stb_o  (upd_stb_o)
    );

    always @(negedge clk) if (rst_n && upd_stb_o) stb_cnt <= stb_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b1; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b0; wq(2 * Q);
    endtask

    // sends a byte, returns 1 when the target pulled SDA low mid-high of the ninth pulse
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            scl = 1'b1;    wq(2 * Q);
            scl = 1'b0;    wq(Q);
        end
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic t_reset;
        chk(sda_pull_o == 1'b0, "R1 pull", int'(sda_pull_o), 0);
        chk(upd_stb_o == 1'b0, "R1 stb", int'(upd_stb_o), 0);
        chk(upd_idx_o == 8'h00, "R1 idx", int'(upd_idx_o), 0);
        chk(upd_data_o == 16'h0000, "R1 data", int'(upd_data_o), 0);
    endtask

    task automatic t_write(input logic [7:0] cmd, input logic [15:0] d, input bit leave_open);
        bit a;
        int s0;
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a); chk(a, "R3 address ack", int'(a), 1);
        send_byte(cmd, a);         chk(a, "R5 command ack", int'(a), 1);
        send_byte(d[15:8], a);     chk(a, "R5 upper ack", int'(a), 1);
        chk(stb_cnt == s0, "R6 no early strobe", stb_cnt - s0, 0);
        send_byte(d[7:0], a);      chk(a, "R5 lower ack", int'(a), 1);
        chk(sda_pull_o == 1'b0, "R9 release after ack", int'(sda_pull_o), 0);
        chk(stb_cnt == s0 + 1, "R6 one strobe", stb_cnt - s0, 1);
        chk(upd_idx_o == cmd, "R6 index", int'(upd_idx_o), int'(cmd));
        chk(upd_data_o == d, "R6 data", int'(upd_data_o), int'(d));
        if (!leave_open) begin
            bus_stop;
            chk(sda_pull_o == 1'b0, "R9 off after stop", int'(sda_pull_o), 0);
        end
    endtask

    task automatic t_mismatch;
        bit a;
        int s0;
        s0 = stb_cnt;
        bus_start;
        send_byte({7'h49, 1'b0}, a); chk(!a, "R4 address nack", int'(a), 0);
        send_byte(8'h03, a);         chk(!a, "R4 later byte nack", int'(a), 0);
        send_byte(8'hAA, a);         chk(!a, "R4 data nack", int'(a), 0);
        send_byte(8'h55, a);
        bus_stop;
        chk(stb_cnt == s0, "R4 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_abort_stop(input logic [7:0] pidx, input logic [15:0] pdat);
        bit a;
        int s0;
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h0F, a);
        send_byte(8'h12, a);
        bus_stop;
        chk(stb_cnt == s0, "R7 stop abort no strobe", stb_cnt - s0, 0);
        chk(upd_data_o == pdat, "R7 stop abort data kept", int'(upd_data_o), int'(pdat));
        chk(upd_idx_o == pidx, "R7 stop abort index kept", int'(upd_idx_o), int'(pidx));
    endtask

    task automatic t_abort_rstart;
        bit a;
        int s0;
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h07, a);
        // repeated start mid-frame, then a fresh complete frame
        t_write(8'h02, 16'h3C96, 1'b0);
        chk(stb_cnt == s0 + 1, "R7 R2 restart single strobe", stb_cnt - s0, 1);
    endtask

    task automatic t_read;
        bit a;
        int s0;
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b1}, a); chk(a, "R8 read address ack", int'(a), 1);
        send_byte(8'h01, a);       chk(!a, "R8 next byte nack", int'(a), 0);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop;
        chk(stb_cnt == s0, "R8 no strobe", stb_cnt - s0, 0);
    endtask

    task automatic t_extra;
        bit a;
        int s0;
        t_write(8'h05, 16'h8001, 1'b1);
        s0 = stb_cnt;
        send_byte(8'h77, a); chk(!a, "R10 extra byte nack", int'(a), 0);
        send_byte(8'h66, a);
        bus_stop;
        chk(stb_cnt == s0, "R10 no extra strobe", stb_cnt - s0, 0);
        chk(upd_data_o == 16'h8001, "R10 data kept", int'(upd_data_o), 16'h8001);
    endtask

    initial begin
        wq(5);
        t_reset;
        rst_n = 1'b1;
        wq(5);
        t_reset;
        t_write(8'h08, 16'hA55A, 1'b0);
        t_write(8'h01, 16'hFFFF, 1'b0);
        t_write(8'hFE, 16'h0001, 1'b0);
        t_mismatch;
        t_abort_stop(8'hFE, 16'h0001);
        t_abort_rstart;
        t_read;
        t_extra;
        t_write(8'h00, 16'h0000, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule